// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block lets synchronous logic fetch 16-bit words from an external asynchronous parallel ROM. A host raises a request with an 18-bit word address. The sequencer drives the ROM address, chip-select and read-strobe lines. It counts clock cycles until each access-time limit has passed, captures the data, and returns it with a one-cycle acknowledge. Between requests it holds chip-select inactive so that the memory stays in standby.

A static configuration input selects how the memory is wired. In word-wide wiring, all sixteen data lines carry data. In byte-wide wiring, only the low eight lines carry data, and the top data pin becomes an extra low-order address bit that the sequencer drives. In that case every word takes two byte reads, lower byte first, and the sequencer joins them. When the configuration changes, the sequencer waits a mode-dependent settling time before it starts another access.

States: IDLE (standby, accepts a request or detects a configuration change), SETTLE (configuration settling wait), ADDR (address and chip-select driven, read strobe held off), STROBE (read strobe low, access wait), SAMPLE (data captured), FLOAT (both strobes high, bus turnaround). Transitions:
- IDLE to SETTLE on a configuration change.
- IDLE to ADDR on an accepted request.
- SETTLE to IDLE when the wait expires.
- ADDR to STROBE when the lead wait expires.
- STROBE to SAMPLE when the strobe wait expires.
- SAMPLE to ADDR for the upper byte in byte-wide wiring.
- SAMPLE to FLOAT after the last capture.
- FLOAT to IDLE when the turnaround wait expires.

Top module: `prom_rd_seq`

## Requirements
- R1: During reset, and whenever the sequencer is idle, `mem_ce_n` and `mem_oe_n` are 1, `ack` is 0, and after reset `rdata` is 0.
- R2: In word-wide wiring (`cfg_word`=1), a request accepted at clock edge e0 gives `ack` high for exactly one cycle after edge e0+T_ACC_CYC+1. At that point `rdata` equals all 16 data lines read at the latched address.
- R3: In byte-wide wiring (`cfg_word`=0), the byte at `mem_alo`=0 is read first and the byte at `mem_alo`=1 second, both from `mem_dq[7:0]`. `rdata` = {second byte, first byte}, and `ack` follows edge e0+2*(T_ACC_CYC+1).
- R4: `mem_oe_n` is never low while `mem_ce_n` is high. It falls only after `mem_ce_n` has been low for T_ACC_CYC-T_OE_CYC cycles.
- R5: Data is captured no earlier than T_ACC_CYC cycles after the address or chip-select change and T_OE_CYC cycles after the read strobe falls.
- R6: In byte-wide wiring, `mem_ce_n` stays low across both byte reads, and only `mem_alo` changes between them. `mem_addr` is stable while `mem_ce_n` is low. `mem_alo_drv` is 1 exactly in byte-wide wiring.
- R7: After the last capture, `mem_ce_n` and `mem_oe_n` stay high for T_DF_CYC cycles. A request already pending is accepted on the next edge, so chip-select falls T_DF_CYC+1 cycles after `ack`.
- R8: A request raised while an access is in progress is ignored. It produces no extra `ack` and does not change the address or data of the access in progress.
- R9: When `cfg_word` changes in IDLE, no access starts for T_SW_WORD_CYC cycles (change to word-wide) or T_SW_BYTE_CYC cycles (change to byte-wide). A pending request then starts one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 1 | 1 = word-wide wiring, 0 = byte-wide wiring |
| req | input | 1 | Read request, accepted only in IDLE |
| addr | input | ADDR_W | Word address of the request |
| ack | output | 1 | One-cycle pulse when rdata is valid |
| rdata | output | DATA_W | Returned word |
| mem_addr | output | ADDR_W | ROM address lines |
| mem_ce_n | output | 1 | ROM chip select, active low |
| mem_oe_n | output | 1 | ROM read strobe, active low |
| mem_alo | output | 1 | Extra low-order byte address (byte-wide wiring) |
| mem_alo_drv | output | 1 | Drive enable for the shared top data pin |
| mem_dq | input | DATA_W | ROM data lines |

## Verification
Timing is counted from the edge that accepts a request. Chip-select falls right after that edge. `ack` appears T_ACC_CYC+1 edges later in word-wide wiring and twice that in byte-wide wiring. A request raised when `ack` is seen starts T_DF_CYC+1 cycles later, or settle+2 cycles after a configuration change. The bench drives stimulus on falling edges and counts falling edges until the chip-select fall and until `ack`, then compares each count with its exact value. The ROM model in the bench returns the inverted word until every access-time limit in nanoseconds has elapsed. Any capture taken too early therefore shows up as a data mismatch.

// File: rtl/prom_seq_pkg.sv
package prom_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_ADDR,
        S_STROBE,
        S_SAMPLE,
        S_FLOAT
    } seq_state_t;
endpackage

// File: rtl/prom_wait_cnt.sv
module prom_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/prom_byte_asm.sv
module prom_byte_asm #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              cap,
    input  logic              cap_last,
    input  logic [DATA_W-1:0] dq,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (cap) begin
                if (cap_last) begin
                    rdata <= byte_mode ? {dq[HALF_W-1:0], low_q} : dq;
                    ack   <= 1'b1;
                end else begin
                    low_q <= dq[HALF_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/prom_seq_fsm.sv
module prom_seq_fsm
    import prom_seq_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int T_ACC_CYC     = 14,
    parameter int T_OE_CYC      = 6,
    parameter int T_DF_CYC      = 4,
    parameter int T_SW_WORD_CYC = 14,
    parameter int T_SW_BYTE_CYC = 8,
    parameter int CNT_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cnt_done,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_alo,
    output logic              mem_alo_drv,
    output logic              cap,
    output logic              cap_last,
    output logic              byte_mode
);
    localparam int LEAD_CYC = T_ACC_CYC - T_OE_CYC;

    seq_state_t        state, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              half_q;
    logic              cfg_q;
    logic              accept;
    logic              second;
    logic              settle_go;

    assign byte_mode = ~cfg_q;

    always_comb begin
        state_d   = state;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        accept    = 1'b0;
        second    = 1'b0;
        settle_go = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cfg_word != cfg_q) begin
                    state_d   = S_SETTLE;
                    cnt_load  = 1'b1;
                    cnt_val   = cfg_word ? CNT_W'(T_SW_WORD_CYC - 1) : CNT_W'(T_SW_BYTE_CYC - 1);
                    settle_go = 1'b1;
                end else if (req) begin
                    state_d  = S_ADDR;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(LEAD_CYC - 1);
                    accept   = 1'b1;
                end
            end
            S_SETTLE: begin
                if (cnt_done) state_d = S_IDLE;
            end
            S_ADDR: begin
                if (cnt_done) begin
                    state_d  = S_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(T_OE_CYC - 1);
                end
            end
            S_STROBE: begin
                if (cnt_done) state_d = S_SAMPLE;
            end
            S_SAMPLE: begin
                cnt_load = 1'b1;
                if (byte_mode && !half_q) begin
                    state_d = S_ADDR;
                    cnt_val = CNT_W'(LEAD_CYC - 1);
                    second  = 1'b1;
                end else begin
                    state_d = S_FLOAT;
                    cnt_val = CNT_W'(T_DF_CYC - 1);
                end
            end
            S_FLOAT: begin
                if (cnt_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            half_q <= 1'b0;
            cfg_q  <= cfg_word;
        end else begin
            state <= state_d;
            if (accept) begin
                addr_q <= addr;
                half_q <= 1'b0;
            end
            if (second)    half_q <= 1'b1;
            if (settle_go) cfg_q  <= cfg_word;
        end
    end

    always_comb begin
        mem_addr    = addr_q;
        mem_alo     = half_q;
        mem_alo_drv = byte_mode;
        mem_ce_n    = 1'b1;
        mem_oe_n    = 1'b1;
        cap         = 1'b0;
        cap_last    = 1'b0;
        unique case (state)
            S_ADDR:   mem_ce_n = 1'b0;
            S_STROBE: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            S_SAMPLE: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                cap      = 1'b1;
                cap_last = ~(byte_mode & ~half_q);
            end
            default: begin
                mem_ce_n = 1'b1;
                mem_oe_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq #(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int T_ACC_CYC     = 14,
    parameter int T_OE_CYC      = 6,
    parameter int T_DF_CYC      = 4,
    parameter int T_SW_WORD_CYC = 14,
    parameter int T_SW_BYTE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_alo,
    output logic              mem_alo_drv,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int MAX_A   = (T_ACC_CYC > T_DF_CYC) ? T_ACC_CYC : T_DF_CYC;
    localparam int MAX_B   = (T_SW_WORD_CYC > T_SW_BYTE_CYC) ? T_SW_WORD_CYC : T_SW_BYTE_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic             cap;
    logic             cap_last;
    logic             byte_mode;

    prom_seq_fsm #(
        .ADDR_W       (ADDR_W),
        .T_ACC_CYC    (T_ACC_CYC),
        .T_OE_CYC     (T_OE_CYC),
        .T_DF_CYC     (T_DF_CYC),
        .T_SW_WORD_CYC(T_SW_WORD_CYC),
        .T_SW_BYTE_CYC(T_SW_BYTE_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .req        (req),
        .addr       (addr),
        .cnt_done   (cnt_done),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_alo    (mem_alo),
        .mem_alo_drv(mem_alo_drv),
        .cap        (cap),
        .cap_last   (cap_last),
        .byte_mode  (byte_mode)
    );

    prom_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .done    (cnt_done)
    );

    prom_byte_asm #(.DATA_W(DATA_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_mode(byte_mode),
        .cap      (cap),
        .cap_last (cap_last),
        .dq       (mem_dq),
        .ack      (ack),
        .rdata    (rdata)
    );
endmodule

// File: rtl/prom_seq_chk.sv
module prom_seq_chk #(
    parameter int ADDR_W   = 18,
    parameter int LEAD_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_alo,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int RUN_W = $clog2(LEAD_CYC + 2);

    logic [RUN_W-1:0] ce_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ce_run <= '0;
        else if (mem_ce_n)
            ce_run <= '0;
        else if (ce_run != RUN_W'(LEAD_CYC + 1))
            ce_run <= ce_run + 1'b1;
    end

    // R2: acknowledge lasts a single cycle
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R4: read strobe only under an active chip select
    a_r4_oe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R4: strobe falls only after the lead time
    a_r4_oe_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (ce_run >= RUN_W'(LEAD_CYC)));

    // R6: address stable while selected
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R6: byte select toggles high only with chip select held low
    a_r6_alo_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_alo) |-> (!mem_ce_n && $past(!mem_ce_n)));

    // R7: chip select stays high at least two cycles after release
    a_r7_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |=> mem_ce_n);
endmodule

bind prom_rd_seq prom_seq_chk #(
    .ADDR_W  (ADDR_W),
    .LEAD_CYC(T_ACC_CYC - T_OE_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n),
    .mem_alo (mem_alo),
    .mem_addr(mem_addr)
);

// File: tb/tb_prom_rd_seq.sv
`timescale 1ns/100ps
module tb_prom_rd_seq;
    localparam int ACC = 14;
    localparam int OEC = 6;
    localparam int DFC = 4;
    localparam int SWW = 14;
    localparam int SWB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word = 1'b1;
    logic        req = 1'b0;
    logic [17:0] addr = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_alo, mem_alo_drv;
    logic [15:0] mem_dq = '0;

    int checks = 0;
    int errors = 0;
    int mon_r4 = 0;
    int mon_r6 = 0;
    int mon_r7 = 0;
    bit done_flag = 1'b0;

    prom_rd_seq #(
        .T_ACC_CYC(ACC), .T_OE_CYC(OEC), .T_DF_CYC(DFC),
        .T_SW_WORD_CYC(SWW), .T_SW_BYTE_CYC(SWB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req(req), .addr(addr),
        .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_alo(mem_alo), .mem_alo_drv(mem_alo_drv),
        .mem_dq(mem_dq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rom_word(input logic [17:0] w);
        return (w[15:0] * 16'd40503) ^ {w[17:16], w[17:4]};
    endfunction

    // ROM model with access limits in ns
    realtime t_addr = 0, t_ce = 0, t_oe = 0, t_cfg = 0, t_rise = -100;
    always @(mem_addr or mem_alo) t_addr = $realtime;
    always @(negedge mem_ce_n) t_ce = $realtime;
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(cfg_word) t_cfg = $realtime;
    always @(posedge mem_ce_n or posedge mem_oe_n) t_rise = $realtime;
    always @(negedge mem_ce_n or negedge mem_oe_n)
        if (rst_n && ($realtime - t_rise) < 20.0) mon_r7++;

    initial begin
        #0.3;
        forever begin
            logic [15:0] w, v;
            bit ok;
            w  = rom_word(mem_addr);
            ok = !mem_ce_n && !mem_oe_n &&
                 ($realtime - t_addr >= 70.0) && ($realtime - t_ce >= 70.0) &&
                 ($realtime - t_oe >= 30.0) &&
                 ($realtime - t_cfg >= (cfg_word ? 70.0 : 40.0));
            v  = cfg_word ? w : {8'hA5, (mem_alo ? w[15:8] : w[7:0])};
            mem_dq = ok ? v : ~v;
            #1;
        end
    end

    // Port monitors
    logic        prev_ce_n = 1'b1;
    logic [17:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && mem_ce_n) mon_r4++;
            if (!prev_ce_n && !mem_ce_n && mem_addr != prev_addr) mon_r6++;
        end
        prev_ce_n = mem_ce_n;
        prev_addr = mem_addr;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Request at a falling edge; count falling edges to chip select and to ack.
    task automatic do_read(input logic [17:0] a, input int exp_n1, input bit inject);
        int n1, n2;
        bit ce_rose;
        logic [15:0] w, exp_d;
        int exp_n2;
        w      = rom_word(a);
        exp_d  = w;
        exp_n2 = cfg_word ? (ACC + 1) : 2 * (ACC + 1);
        req  = 1'b1;
        addr = a;
        n1 = 0;
        do begin
            @(negedge clk);
            n1++;
        end while (mem_ce_n && n1 < 100);
        req  = 1'b0;
        addr = ~a;
        check(n1 == exp_n1, "R7/R9 start delay", n1, exp_n1);
        n2 = 0;
        ce_rose = 1'b0;
        while (!ack && n2 < 200) begin
            @(negedge clk);
            n2++;
            if (inject && n2 == 4) req = 1'b1;
            if (inject && n2 == 5) req = 1'b0;
            if (!ack && mem_ce_n) ce_rose = 1'b1;
        end
        if (cfg_word) check(n2 == exp_n2, "R2 ack latency", n2, exp_n2);
        else          check(n2 == exp_n2, "R3 ack latency", n2, exp_n2);
        check(rdata == exp_d, cfg_word ? "R2/R5 word data" : "R3/R5 byte data", rdata, exp_d);
        if (!cfg_word) check(!ce_rose, "R6 ce held across bytes", ce_rose, 0);
    endtask

    function automatic logic [17:0] pick(input int i);
        if (i == 0) return '0;
        if (i == 1) return '1;
        if (i < 20) return 18'(1) << (i - 2);
        return 18'(i * 9973);
    endfunction

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(mem_ce_n && mem_oe_n && !ack, "R1 reset standby", {mem_ce_n, mem_oe_n, ack}, 3'b110);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(mem_ce_n && mem_oe_n && !ack && rdata == 0, "R1 idle after reset",
              {mem_ce_n, mem_oe_n, ack, rdata}, {3'b110, 16'h0});
        check(mem_alo_drv == 1'b0, "R6 word mode no drive", mem_alo_drv, 0);

        for (int i = 0; i < 24; i++) do_read(pick(i), (i == 0) ? 1 : DFC + 1, 1'b0);

        // R8: request pulse during an access is ignored
        repeat (10) @(negedge clk);
        do_read(18'h2AAAA, 1, 1'b1);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (ack || !mem_ce_n) extra = 1'b1;
            end
            check(!extra, "R8 busy request ignored", extra, 0);
            check(mem_ce_n && mem_oe_n, "R1 standby when idle", {mem_ce_n, mem_oe_n}, 2'b11);
        end

        // R9: change to byte-wide
        cfg_word = 1'b0;
        do_read(18'h1F0F0, SWB + 2, 1'b0);
        check(mem_alo_drv == 1'b1, "R6 byte mode drives pin", mem_alo_drv, 1);
        for (int i = 0; i < 24; i++) do_read(pick(i), DFC + 1, 1'b0);

        repeat (10) @(negedge clk);
        do_read(18'h00F0F, 1, 1'b1);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (ack || !mem_ce_n) extra = 1'b1;
            end
            check(!extra, "R8 busy request ignored byte", extra, 0);
        end

        // R9: change back to word-wide
        cfg_word = 1'b1;
        do_read(18'h3C3C3, SWW + 2, 1'b0);
        repeat (10) @(negedge clk);

        check(mon_r4 == 0, "R4 strobe without select", mon_r4, 0);
        check(mon_r6 == 0, "R6 address moved while selected", mon_r6, 0);
        check(mon_r7 == 0, "R7 float gap violated", mon_r7, 0);
        finish_run();
    end
endmodule